// File: doc/BRIEF.md
# Board Boot-Mode and Reset Sequencer

This block sits inside a board controller next to an FPGA SoC. It decides which boot source the SoC sees on its three boot-mode pins, and it holds the SoC in reset until the board is ready. The board is ready when the reset button, both power-good monitors and the enable line are all high. The initial boot source comes from two strap inputs.

A register-write port can take over from the straps. It carries an address, a data byte and a strobe, as produced by an I2C target front end. Software can pick a boot source through this port. It can also pull the bank-voltage select pin low for boundary scan, which forces JTAG boot. Any write that changes the effective boot source or the state of the bank pin restarts the SoC through a timed reset. The block also drives the open-drain power-good pin.

The boot-mode pins change only while the SoC is held in reset. The SoC therefore always samples a settled value.

Top module: `boot_rst_seq`

## Requirements
- R1: `pgood_low_o` is 1 (pin pulled low) whenever any of `pg_3v3_i`, `pg_all_i` or `en_i` is 0. It is 0 (pin released) when all three are 1. This output is combinational from the pins.
- R2: The six board inputs pass through SYNC_STAGES flops before they are used. `fpga_rst_no` is 0 while any synchronized one of `resin_i`, `pg_3v3_i`, `pg_all_i`, `en_i` is 0. It rises on the RST_DLY-th clock edge after the last edge at which the synchronized condition was false.
- R3: The straps decode as {`strap_pg_i`,`strap_mode_i`}: 00 and 01 select JTAG, 10 selects SD card, 11 selects QSPI. `boot_mode_o` encodes JTAG as 3'b000, QSPI as 3'b001 and SD card as 3'b101.
- R4: A strobed write to address 0x01 with data 0x91, 0x92 or 0x93 overrides the straps with JTAG, QSPI or SD card respectively.
- R5: A software boot-mode write that changes the active override forces a reset. `fpga_rst_no` goes low after the write edge and stays low for RST_DLY edges. Repeating the same write forces no reset.
- R6: Writing 0x61 to address 0x01 sets `vsel_low_o`. While it is set, the boot source is JTAG regardless of override or straps. The write forces a reset if the pin was released.
- R7: Writing 0x64 to address 0x01 clears `vsel_low_o`. The write forces a reset if the pin was low. The boot source then falls back to the override, or to the straps if there is no override.
- R8: `boot_mode_o` takes a new value only on edges where the reset was active before the edge. Otherwise it holds.
- R9: Writes to other addresses, with other data, or without the strobe leave every output unchanged.
- R10: `sw_mode_set_o` is 1 once a software boot-mode override is active. `rst_active_o` is 1 exactly while `fpga_rst_no` is 0.
- R11: An asynchronous reset (`rst_ni` low) clears the override and the bank pin, asserts the SoC reset and sets `boot_mode_o` to JTAG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| resin_i | input | 1 | Reset button, active low |
| pg_3v3_i | input | 1 | 3.3 V power-good |
| pg_all_i | input | 1 | All-rails power-good |
| en_i | input | 1 | Power enable |
| strap_pg_i | input | 1 | Boot strap, upper bit (read from the power-good pin) |
| strap_mode_i | input | 1 | Boot strap, lower bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register address |
| wr_data_i | input | 8 | Register data |
| fpga_rst_no | output | 1 | SoC reset, active low |
| boot_mode_o | output | 3 | Boot-mode pins |
| pgood_low_o | output | 1 | Drive-low enable for the open-drain power-good pin |
| vsel_low_o | output | 1 | Drive-low enable for the bank-voltage select pin |
| sw_mode_set_o | output | 1 | Software boot override active |
| rst_active_o | output | 1 | SoC reset currently held |

## Verification
Each result has its own latency, and every check is timed to it:
- A register write acts on the edge that samples it. The bank pin, the override flag and the reset are therefore visible right after that edge.
- The boot pins follow one edge later. The reset releases RST_DLY edges after the write.
- A board input reaches the reset timer only after SYNC_STAGES edges.
- The power-good pin has no latency and is checked one nanosecond after the input moves.

The bench model applies these delays cycle by cycle and compares all outputs shortly after every rising edge. Directed checks sample only after the longest of these delays has passed.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    BM_JTAG = 3'b000,
    BM_QSPI = 3'b001,
    BM_SD   = 3'b101
  } boot_mode_e;

  localparam logic [7:0] CMD_SW_JTAG  = 8'h91;
  localparam logic [7:0] CMD_SW_QSPI  = 8'h92;
  localparam logic [7:0] CMD_SW_SD    = 8'h93;
  localparam logic [7:0] CMD_VSEL_LOW = 8'h61;
  localparam logic [7:0] CMD_VSEL_REL = 8'h64;

  function automatic boot_mode_e strap_to_mode(input logic [1:0] strap);
    case (strap)
      2'b10:   return BM_SD;
      2'b11:   return BM_QSPI;
      default: return BM_JTAG;
    endcase
  endfunction
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < STAGES; i++) begin : gen_stg
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] d;
    if (i == 0) begin : gen_first
      assign d = d_i;
    end else begin : gen_next
      assign d = gen_stg[i-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end
  end

  assign q_o = gen_stg[STAGES-1].q;
endmodule

// File: rtl/bsr_cmd_regs.sv
module bsr_cmd_regs
  import bsr_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       sw_ovr_o,
  output boot_mode_e sw_mode_o,
  output logic       vsel_low_o,
  output logic       force_o
);
  logic       ovr_q, ovr_d;
  boot_mode_e mode_q, mode_d;
  logic       vsel_q, vsel_d;
  logic       hit, sw_cmd;
  boot_mode_e req_mode;

  assign hit = wr_en_i && (wr_addr_i == REG_ADDR);

  always_comb begin
    sw_cmd   = 1'b0;
    req_mode = BM_JTAG;
    case (wr_data_i)
      CMD_SW_JTAG: begin sw_cmd = 1'b1; req_mode = BM_JTAG; end
      CMD_SW_QSPI: begin sw_cmd = 1'b1; req_mode = BM_QSPI; end
      CMD_SW_SD:   begin sw_cmd = 1'b1; req_mode = BM_SD;   end
      default: ;
    endcase
  end

  always_comb begin
    ovr_d   = ovr_q;
    mode_d  = mode_q;
    vsel_d  = vsel_q;
    force_o = 1'b0;
    if (hit) begin
      if (sw_cmd) begin
        // restart only when the effective override actually changes
        force_o = !ovr_q || (mode_q != req_mode);
        ovr_d   = 1'b1;
        mode_d  = req_mode;
      end else if (wr_data_i == CMD_VSEL_LOW) begin
        force_o = !vsel_q;
        vsel_d  = 1'b1;
      end else if (wr_data_i == CMD_VSEL_REL) begin
        force_o = vsel_q;
        vsel_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      mode_q <= BM_JTAG;
      vsel_q <= 1'b0;
    end else begin
      ovr_q  <= ovr_d;
      mode_q <= mode_d;
      vsel_q <= vsel_d;
    end
  end

  assign sw_ovr_o   = ovr_q;
  assign sw_mode_o  = mode_q;
  assign vsel_low_o = vsel_q;
endmodule

// File: rtl/bsr_rst_timer.sv
module bsr_rst_timer #(
  parameter int unsigned DLY = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] DONE = CW'(DLY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != DONE)  cnt_q <= cnt_q + 1'b1;
  end

  assign active_o = (cnt_q != DONE);
endmodule

// File: rtl/boot_rst_seq.sv
module boot_rst_seq
  import bsr_pkg::*;
#(
  parameter int unsigned RST_DLY     = 65536,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  REG_ADDR    = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       resin_i,
  input  logic       pg_3v3_i,
  input  logic       pg_all_i,
  input  logic       en_i,
  input  logic       strap_pg_i,
  input  logic       strap_mode_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       fpga_rst_no,
  output logic [2:0] boot_mode_o,
  output logic       pgood_low_o,
  output logic       vsel_low_o,
  output logic       sw_mode_set_o,
  output logic       rst_active_o
);
  localparam int unsigned NIN = 6;

  logic [NIN-1:0] pins_s;
  logic           pwr_ok, force_rst, rst_act;
  logic           sw_ovr, vsel_low;
  boot_mode_e     sw_mode, tgt_mode, bm_q;

  bsr_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({strap_pg_i, strap_mode_i, en_i, pg_all_i, pg_3v3_i, resin_i}),
    .q_o   (pins_s)
  );

  bsr_cmd_regs #(.REG_ADDR(REG_ADDR)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sw_ovr_o  (sw_ovr),
    .sw_mode_o (sw_mode),
    .vsel_low_o(vsel_low),
    .force_o   (force_rst)
  );

  assign pwr_ok = &pins_s[3:0];

  bsr_rst_timer #(.DLY(RST_DLY)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!pwr_ok || force_rst),
    .active_o(rst_act)
  );

  always_comb begin
    if (vsel_low)    tgt_mode = BM_JTAG;
    else if (sw_ovr) tgt_mode = sw_mode;
    else             tgt_mode = strap_to_mode(pins_s[5:4]);
  end

  // pins follow the target only while the SoC is held in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bm_q <= BM_JTAG;
    else if (rst_act) bm_q <= tgt_mode;
  end

  assign boot_mode_o   = bm_q;
  assign fpga_rst_no   = !rst_act;
  assign rst_active_o  = rst_act;
  assign pgood_low_o   = !(pg_3v3_i && pg_all_i && en_i);
  assign vsel_low_o    = vsel_low;
  assign sw_mode_set_o = sw_ovr;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pg_3v3_i,
  input logic       pg_all_i,
  input logic       en_i,
  input logic       wr_en_i,
  input logic [7:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       fpga_rst_no,
  input logic [2:0] boot_mode_o,
  input logic       pgood_low_o,
  input logic       vsel_low_o,
  input logic       sw_mode_set_o
);
  logic reg_hit;
  assign reg_hit = wr_en_i && (wr_addr_i == 8'h01);

  a_r1_pgood_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_3v3_i || !pg_all_i || !en_i) |-> pgood_low_o);

  a_r1_pgood_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_3v3_i && pg_all_i && en_i) |-> !pgood_low_o);

  a_r5_sw_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_hit && (wr_data_i inside {8'h91, 8'h92, 8'h93}) && !sw_mode_set_o)
      |=> (!fpga_rst_no && sw_mode_set_o));

  a_r6_vsel_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_hit && wr_data_i == 8'h61 && !vsel_low_o) |=> (!fpga_rst_no && vsel_low_o));

  a_r6_vsel_jtag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsel_low_o && fpga_rst_no) |-> (boot_mode_o == 3'b000));

  a_r7_vsel_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_hit && wr_data_i == 8'h64 && vsel_low_o) |=> (!fpga_rst_no && !vsel_low_o));

  a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpga_rst_no && $past(fpga_rst_no)) |-> $stable(boot_mode_o));
endmodule

bind boot_rst_seq bsr_checker u_bsr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pg_3v3_i     (pg_3v3_i),
  .pg_all_i     (pg_all_i),
  .en_i         (en_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .fpga_rst_no  (fpga_rst_no),
  .boot_mode_o  (boot_mode_o),
  .pgood_low_o  (pgood_low_o),
  .vsel_low_o   (vsel_low_o),
  .sw_mode_set_o(sw_mode_set_o)
);

// File: tb/boot_rst_seq_tb.sv
module boot_rst_seq_tb;
  localparam int DLY = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic resin = 1'b1, pg3 = 1'b1, pga = 1'b1, en = 1'b1, spg = 1'b1, smd = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic fpga_rst_n, pgood_low, vsel_low, sw_set, rst_act;
  logic [2:0] bm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  boot_rst_seq #(.RST_DLY(DLY), .SYNC_STAGES(2), .REG_ADDR(8'h01)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .resin_i(resin), .pg_3v3_i(pg3), .pg_all_i(pga),
    .en_i(en), .strap_pg_i(spg), .strap_mode_i(smd), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .fpga_rst_no(fpga_rst_n),
    .boot_mode_o(bm), .pgood_low_o(pgood_low), .vsel_low_o(vsel_low),
    .sw_mode_set_o(sw_set), .rst_active_o(rst_act)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int m_s1 [6];
  int m_s2 [6];
  int m_cnt = 0, m_bm = 0, m_swm = 0;
  bit m_ovr = 0, m_vsel = 0;

  function automatic int strap_code(int hi, int lo);
    if (hi == 1 && lo == 1) return 1;
    if (hi == 1 && lo == 0) return 5;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      foreach (m_s1[i]) begin m_s1[i] = 0; m_s2[i] = 0; end
      m_cnt = 0; m_bm = 0; m_swm = 0; m_ovr = 0; m_vsel = 0;
    end else begin
      bit cond, act, frc;
      int tgt, want;
      cond = m_s2[0] && m_s2[1] && m_s2[2] && m_s2[3];
      act  = (m_cnt != DLY);
      tgt  = m_vsel ? 0 : (m_ovr ? m_swm : strap_code(m_s2[5], m_s2[4]));
      frc  = 0;
      if (wr_en && wr_addr == 8'h01) begin
        want = -1;
        if (wr_data == 8'h91) want = 0;
        if (wr_data == 8'h92) want = 1;
        if (wr_data == 8'h93) want = 5;
        if (want >= 0) begin
          if (!m_ovr || m_swm != want) frc = 1;
          m_ovr = 1; m_swm = want;
        end else if (wr_data == 8'h61) begin
          if (!m_vsel) frc = 1;
          m_vsel = 1;
        end else if (wr_data == 8'h64) begin
          if (m_vsel) frc = 1;
          m_vsel = 0;
        end
      end
      if (!cond || frc) m_cnt = 0;
      else if (m_cnt < DLY) m_cnt++;
      if (act) m_bm = tgt;
      foreach (m_s2[i]) m_s2[i] = m_s1[i];
      m_s1[0] = resin; m_s1[1] = pg3; m_s1[2] = pga; m_s1[3] = en;
      m_s1[4] = smd;   m_s1[5] = spg;
    end
    #1;
    if (!done) begin
      check("R1 pgood_low", pgood_low, !(pg3 && pga && en));
      check("R2 fpga_rst_n", fpga_rst_n, m_cnt == DLY);
      check("R8 boot_mode", bm, m_bm);
      check("R6 vsel_low", vsel_low, m_vsel);
      check("R10 sw_mode_set", sw_set, m_ovr);
      check("R10 rst_active", rst_act, m_cnt != DLY);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R11 reset state
    check("R11 rst held", fpga_rst_n, 0);
    check("R11 boot jtag", bm, 0);
    check("R11 vsel", vsel_low, 0);
    rst_ni = 1'b1;
    cyc(DLY + 6);
    check("R3 strap 11 qspi", bm, 1);
    check("R2 released", fpga_rst_n, 1);

    spg = 1'b1; smd = 1'b0;
    cyc(5);
    check("R8 strap held", bm, 1);
    en = 1'b0; #1;
    check("R1 pgood pulled", pgood_low, 1);
    cyc(4);
    check("R2 enable low", fpga_rst_n, 0);
    en = 1'b1;
    cyc(DLY + 5);
    check("R3 strap 10 sd", bm, 5);

    spg = 1'b0; smd = 1'b1;
    resin = 1'b0; cyc(3); resin = 1'b1;
    cyc(DLY + 6);
    check("R3 strap 01 jtag", bm, 0);
    check("R2 resin release", fpga_rst_n, 1);

    wr(8'h01, 8'h92);
    check("R5 forced reset", fpga_rst_n, 0);
    cyc(DLY + 3);
    check("R4 sw qspi", bm, 1);
    check("R10 override flag", sw_set, 1);
    wr(8'h01, 8'h92);
    cyc(2);
    check("R5 repeat no reset", fpga_rst_n, 1);
    wr(8'h01, 8'h93);
    cyc(DLY + 3);
    check("R4 sw sd", bm, 5);

    wr(8'h01, 8'h55);
    wr(8'h02, 8'h91);
    @(negedge clk); wr_addr = 8'h01; wr_data = 8'h91; @(negedge clk);
    cyc(2);
    check("R9 ignored rst", fpga_rst_n, 1);
    check("R9 ignored mode", bm, 5);

    wr(8'h01, 8'h61);
    check("R6 vsel set", vsel_low, 1);
    check("R6 forced reset", fpga_rst_n, 0);
    cyc(DLY + 3);
    check("R6 jtag forced", bm, 0);
    wr(8'h01, 8'h61);
    cyc(2);
    check("R6 repeat no reset", fpga_rst_n, 1);

    wr(8'h01, 8'h64);
    check("R7 vsel released", vsel_low, 0);
    check("R7 forced reset", fpga_rst_n, 0);
    cyc(DLY + 3);
    check("R7 back to override", bm, 5);

    @(negedge clk); rst_ni = 1'b0; #1;
    check("R11 async boot", bm, 0);
    check("R11 async rst", rst_act, 1);
    check("R11 async ovr", sw_set, 0);
    cyc(2); rst_ni = 1'b1;
    cyc(DLY + 6);
    check("R11 straps again", bm, 0);
    check("R11 released", fpga_rst_n, 1);
    finish_run();
  end
endmodule